// File: doc/BRIEF.md
# Banked Cache Identification Register File

This block is a small register bank that reports cache geometry to software over a simple register bus. Software reads two fixed identification words: one describing which cache levels exist and what type each is, and one describing cache line and layout properties. Both come from parameters. A third word reports the size of one chosen cache. That word is taken from a parameter array of size descriptors.

The descriptor returned is chosen by a selection register, and there is one copy of that register for each security state. The secure attribute of each bus access decides which copy is written and which copy steers the read. The selection index packs a level field in bits [3:1] and an instruction-not-data flag in bit 0. As a result, array entry 0 is the level-1 data cache, entry 1 the level-1 instruction cache, entry 2 the level-2 data cache, and so on.

When the level word shows no caches at all, the selection path reads as zero and ignores writes. Read data is registered. The bus has no wait states and no error response.

Top module: `cache_id_regs`

## Requirements
- R1: A read at offset 0xD78 returns the parameter LEVEL_ID_VAL, whatever the secure attribute and selection state.
- R2: A read at offset 0xD7C returns the parameter TYPE_VAL.
- R3: A read at offset 0xD80 returns size array entry number sel[3:0], where sel is the selection copy of the current security state. Entry i is SIZE_VALS[32*i+31:32*i], and index = 2*level + (1 if instruction cache).
- R4: Two selection copies exist. secure_i=1 selects copy 1 and secure_i=0 selects copy 0, for both writes and reads. A write to one copy leaves the other unchanged.
- R5: The selection register sits at offset 0xD84. A write stores wdata_i[3:0], and a read returns that value in bits [3:0] with bits [31:4] zero.
- R6: When LEVEL_ID_VAL[20:0] is zero (no caches), the selection register reads as zero and ignores writes. A size read then returns entry 0.
- R7: A size read returns zero when the index is at or beyond N_SIZE, or when the level field sel[3:1] equals 7.
- R8: Writes to offsets 0xD78, 0xD7C and 0xD80 change nothing that any later read can observe.
- R9: rdata_o carries the read result in the cycle after rd_i is high. It is zero in a cycle after rd_i was low, and it is zero for a read at any unmapped offset.
- R10: Reset clears both selection copies to zero.
- R11: When a read and a write of the selection register occur in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte offset of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Security state of the access (1 = secure) |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions assume that the address, strobes and secure attribute are stable across each rising edge, and that the level and type words are compile-time constants. The bench drives every input on the falling edge and holds it for one full cycle, so every access is captured exactly once. It also uses two instances on one shared bus: one configured with caches and one without. This lets one stimulus sequence exercise both the normal path and the collapsed no-cache path.

// File: rtl/cid_pkg.sv
package cid_pkg;
  localparam int SEL_W  = 4;
  localparam int N_BANK = 2;
  localparam int DATA_W = 32;

  typedef logic [SEL_W-1:0] sel_t;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_LEVEL,
    REG_TYPE,
    REG_SIZE,
    REG_SEL
  } cid_reg_e;
endpackage

// File: rtl/cid_decode.sv
module cid_decode
  import cid_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFF_LEVEL = 12'hD78,
  parameter logic [ADDR_W-1:0] OFF_TYPE  = 12'hD7C,
  parameter logic [ADDR_W-1:0] OFF_SIZE  = 12'hD80,
  parameter logic [ADDR_W-1:0] OFF_SEL   = 12'hD84
) (
  input  logic [ADDR_W-1:0] addr_i,
  output cid_reg_e          hit_o
);
  always_comb begin
    unique case (addr_i)
      OFF_LEVEL: hit_o = REG_LEVEL;
      OFF_TYPE:  hit_o = REG_TYPE;
      OFF_SIZE:  hit_o = REG_SIZE;
      OFF_SEL:   hit_o = REG_SEL;
      default:   hit_o = REG_NONE;
    endcase
  end
endmodule

// File: rtl/cid_sel_bank.sv
module cid_sel_bank
  import cid_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic bank_i,
  input  sel_t wdata_i,
  input  logic caches_i,
  output sel_t sel_o
);
  logic [N_BANK-1:0][SEL_W-1:0] sel_q;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   sel_q[b] <= '0;
      else if (wr_en_i && caches_i && (bank_i == b)) sel_q[b] <= wdata_i;
    end

    // other security state's copy untouched
    p_bank_isolated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (bank_i != b)) |=> $stable(sel_q[b]));

    p_nocache_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !caches_i |=> $stable(sel_q[b]));
  end

  assign sel_o = caches_i ? sel_q[bank_i] : '0;

  p_bank_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && caches_i) |=> (sel_q[$past(bank_i)] == $past(wdata_i)));
endmodule

// File: rtl/cid_size_mux.sv
module cid_size_mux
  import cid_pkg::*;
#(
  parameter int N_SIZE = 4,
  parameter logic [N_SIZE*DATA_W-1:0] SIZE_VALS = '0
) (
  input  sel_t              idx_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int LVL_W = SEL_W - 1;

  logic [DATA_W-1:0] entry [N_SIZE];
  for (genvar i = 0; i < N_SIZE; i++) begin : g_entry
    assign entry[i] = SIZE_VALS[i*DATA_W +: DATA_W];
  end

  logic lvl_bad;
  assign lvl_bad = &idx_i[SEL_W-1:1];

  always_comb begin
    word_o = '0;
    for (int i = 0; i < N_SIZE; i++) begin
      if (!lvl_bad && (int'(idx_i) == i)) word_o = entry[i];
    end
  end

  initial assert (LVL_W == 3);
endmodule

// File: rtl/cache_id_regs.sv
module cache_id_regs
  import cid_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [DATA_W-1:0] LEVEL_ID_VAL = 32'h0000_0023,
  parameter logic [DATA_W-1:0] TYPE_VAL     = 32'h8303_C003,
  parameter int N_SIZE = 4,
  parameter logic [N_SIZE*DATA_W-1:0] SIZE_VALS =
    {32'hF007_E01A, 32'hF003_E019, 32'hF01F_E01A, 32'hF00F_E019}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic              secure_i,
  output logic [31:0]       rdata_o
);
  localparam logic [ADDR_W-1:0] OFF_LEVEL = ADDR_W'(12'hD78);
  localparam logic [ADDR_W-1:0] OFF_TYPE  = ADDR_W'(12'hD7C);
  localparam logic [ADDR_W-1:0] OFF_SIZE  = ADDR_W'(12'hD80);
  localparam logic [ADDR_W-1:0] OFF_SEL   = ADDR_W'(12'hD84);
  localparam logic CACHES = |LEVEL_ID_VAL[20:0];

  cid_reg_e          hit;
  sel_t              sel_cur;
  logic [DATA_W-1:0] size_word;
  logic [DATA_W-1:0] rd_mux;

  cid_decode #(
    .ADDR_W(ADDR_W), .OFF_LEVEL(OFF_LEVEL), .OFF_TYPE(OFF_TYPE),
    .OFF_SIZE(OFF_SIZE), .OFF_SEL(OFF_SEL)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit)
  );

  cid_sel_bank u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_i && (hit == REG_SEL)),
    .bank_i  (secure_i),
    .wdata_i (wdata_i[SEL_W-1:0]),
    .caches_i(CACHES),
    .sel_o   (sel_cur)
  );

  cid_size_mux #(.N_SIZE(N_SIZE), .SIZE_VALS(SIZE_VALS)) u_size (
    .idx_i (sel_cur),
    .word_o(size_word)
  );

  always_comb begin
    unique case (hit)
      REG_LEVEL: rd_mux = LEVEL_ID_VAL;
      REG_TYPE:  rd_mux = TYPE_VAL;
      REG_SIZE:  rd_mux = size_word;
      REG_SEL:   rd_mux = {{(DATA_W-SEL_W){1'b0}}, sel_cur};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
    else           rdata_o <= '0;
  end

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
  p_level_fixed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFF_LEVEL) |=> (rdata_o == LEVEL_ID_VAL));
  p_type_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFF_TYPE) |=> (rdata_o == TYPE_VAL));
  p_sel_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFF_SEL) |=> (rdata_o[31:SEL_W] == '0));
  p_size_invalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFF_SIZE && (int'(sel_cur) >= N_SIZE || &sel_cur[3:1]))
      |=> (rdata_o == '0));
endmodule

// File: tb/cache_id_regs_test.sv
module cache_id_regs_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] LVL  = 32'h0000_0023;
  localparam logic [31:0] TYP  = 32'h8303_C003;
  localparam logic [127:0] SZ  = {32'hF007_E01A, 32'hF003_E019, 32'hF01F_E01A, 32'hF00F_E019};
  localparam logic [11:0] A_LVL = 12'hD78, A_TYP = 12'hD7C, A_SZ = 12'hD80, A_SEL = 12'hD84;

  logic        clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic        rd = 0, wr = 0, sec = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_nc;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_id_regs #(.LEVEL_ID_VAL(LVL), .TYPE_VAL(TYP), .SIZE_VALS(SZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .secure_i(sec), .rdata_o(rdata));

  cache_id_regs #(.LEVEL_ID_VAL(32'h0900_0000), .TYPE_VAL(TYP), .SIZE_VALS(SZ)) uut_nc (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .secure_i(sec), .rdata_o(rdata_nc));

  function automatic logic [31:0] sz(int i);
    return SZ[i*32 +: 32];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic s, logic [31:0] d);
    @(negedge clk); addr = a; sec = s; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(logic [11:0] a, logic s, output logic [31:0] d, output logic [31:0] dnc);
    @(negedge clk); addr = a; sec = s; rd = 1;
    @(negedge clk); rd = 0; d = rdata; dnc = rdata_nc;
  endtask

  task automatic t_reset;
    logic [31:0] d, n;
    chk("R9 idle", rdata, 32'h0);
    bus_rd(A_SEL, 0, d, n); chk("R10 sel ns", d, 0);
    bus_rd(A_SEL, 1, d, n); chk("R10 sel s", d, 0);
  endtask

  task automatic t_fixed;
    logic [31:0] d, n;
    bus_rd(A_LVL, 0, d, n); chk("R1 level ns", d, LVL);
    bus_rd(A_LVL, 1, d, n); chk("R1 level s", d, LVL);
    bus_rd(A_TYP, 1, d, n); chk("R2 type", d, TYP);
  endtask

  task automatic t_size_walk;
    logic [31:0] d, n;
    for (int i = 0; i < 4; i++) begin
      bus_wr(A_SEL, 0, i);
      bus_rd(A_SZ, 0, d, n); chk("R3 size entry", d, sz(i));
    end
  endtask

  task automatic t_banks;
    logic [31:0] d, n;
    bus_wr(A_SEL, 1, 2);
    bus_wr(A_SEL, 0, 1);
    bus_rd(A_SZ, 1, d, n);  chk("R4 secure size", d, sz(2));
    bus_rd(A_SZ, 0, d, n);  chk("R4 nonsecure size", d, sz(1));
    bus_rd(A_SEL, 1, d, n); chk("R4 secure sel", d, 2);
    bus_rd(A_SEL, 0, d, n); chk("R4 nonsecure sel", d, 1);
  endtask

  task automatic t_width_and_range;
    logic [31:0] d, n;
    bus_wr(A_SEL, 0, 32'hFFFF_FFF5);
    bus_rd(A_SEL, 0, d, n); chk("R5 stored bits", d, 32'h5);
    bus_rd(A_SZ, 0, d, n);  chk("R7 past array", d, 0);
    bus_wr(A_SEL, 0, 4);
    bus_rd(A_SZ, 0, d, n);  chk("R7 index 4", d, 0);
    bus_wr(A_SEL, 0, 32'hE);
    bus_rd(A_SZ, 0, d, n);  chk("R7 level 7", d, 0);
  endtask

  task automatic t_ro_writes;
    logic [31:0] d, n;
    bus_wr(A_SEL, 0, 3);
    bus_wr(A_LVL, 0, 32'h1234_5678);
    bus_wr(A_TYP, 0, 32'hDEAD_BEEF);
    bus_wr(A_SZ, 0, 32'h0);
    bus_rd(A_LVL, 0, d, n); chk("R8 level kept", d, LVL);
    bus_rd(A_TYP, 0, d, n); chk("R8 type kept", d, TYP);
    bus_rd(A_SZ, 0, d, n);  chk("R8 size kept", d, sz(3));
    bus_rd(A_SEL, 0, d, n); chk("R8 sel kept", d, 3);
  endtask

  task automatic t_unmapped;
    logic [31:0] d, n;
    bus_rd(12'hD88, 0, d, n); chk("R9 unmapped", d, 0);
    @(negedge clk); chk("R9 after read", rdata, 0);
  endtask

  task automatic t_nocache;
    logic [31:0] d, n;
    bus_wr(A_SEL, 1, 3);
    bus_rd(A_SEL, 1, d, n); chk("R6 sel zero", n, 0);
    bus_rd(A_SZ, 1, d, n);  chk("R6 size entry0", n, sz(0));
    chk("R6 cached copy written", d, sz(3));
  endtask

  task automatic t_rd_wr_same;
    logic [31:0] d;
    bus_wr(A_SEL, 0, 1);
    @(negedge clk); addr = A_SEL; sec = 0; wdata = 2; rd = 1; wr = 1;
    @(negedge clk); rd = 0; wr = 0; d = rdata;
    chk("R11 old value", d, 1);
    @(negedge clk); addr = A_SEL; rd = 1;
    @(negedge clk); rd = 0;
    chk("R11 new value", rdata, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fixed();
    t_size_walk();
    t_banks();
    t_width_and_range();
    t_ro_writes();
    t_unmapped();
    t_nocache();
    t_rd_wr_same();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule